// File: doc/BRIEF.md
# SD Card Clock Divider and Clock Control Register

This block holds the 16-bit clock control word of an SD host controller and uses it to produce the card clock from the base clock. The word is written whole over a one-cycle write strobe and is always readable on a parallel read bus. It carries these fields:

- an internal clock enable
- a read-only flag that shows the internal clock has settled
- a card clock enable
- a PLL control bit, which is stored but has no effect
- a 10-bit divider, split across two fields

The card clock comes out in two forms, both synchronous to the base clock. The first is a level that follows the divided waveform. The second is a one-cycle tick at the start of every card clock period. Downstream logic can use the tick as a clock enable, or can gate the base clock with the level. The divider is reloaded only at a period boundary, so a change of rate never gives a truncated high or low phase. The card clock runs only once the internal clock is enabled and settled and the card clock enable is set.

Top module: `cardclk_divider`

## Requirements
- R1: After reset, the read bus returns 0x0000 and clkStable, cardLevel and cardTick are all 0.
- R2: Divider bits 7:0 are written and read at word bits 15:8, and divider bits 9:8 at word bits 7:6. The read bus returns the stored divider at those positions.
- R3: Word bit 0 is the internal clock enable. Word bit 1 (and clkStable) reads 1 exactly STABLE_CYCLES base clock cycles after the write that sets bit 0, and stays 1 while bit 0 stays 1.
- R4: In the same cycle that a write clears word bit 0, word bit 1 and clkStable read 0.
- R5: Write data on word bits 1, 5 and 4 is ignored. Bits 5:4 always read 0, and bit 1 only ever shows the settle state.
- R6: Word bit 2 (card clock enable) and word bit 3 (PLL control) are stored and read back. Bit 3 has no effect on the card clock.
- R7: The card clock runs only while word bits 0, 1 and 2 are all 1. Otherwise cardLevel and cardTick are 0. When the clock starts, the first tick appears one cycle after these bits first read all 1.
- R8: With divider N > 0, each card clock period lasts 2N base cycles. cardLevel is 1 for the first N cycles and 0 for the last N, and cardTick is 1 only in the first cycle.
- R9: With divider 0, the base clock passes through: cardTick and cardLevel are 1 in every cycle while the clock runs.
- R10: A divider written while the clock runs is used only once the period in progress has completed with the old divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word write data |
| rdData | output | 16 | Control word read data |
| clkStable | output | 1 | Internal clock settled (same as word bit 1) |
| cardLevel | output | 1 | Divided card clock waveform |
| cardTick | output | 1 | One-cycle strobe at the start of each card clock period |

## Verification
The embedded assertions check the following on every cycle:
- the settle flag rises only under a held enable, and drops together with it;
- the half-period counter never passes the active divider;
- the active divider never changes in the middle of a period;
- a closed gate always stops the generator on the next edge;
- each start of the generator begins with a tick.

Three things can only be shown by the bench's scenarios, because they depend on the whole history of writes:
- the exact settle delay;
- the mapping of the divider fields to word bits;
- the measured period and high time across divider changes from 3 to 1 to 5 to 0, including the one old-rate period that completes after each change.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  localparam int DIV_W = 10;
  localparam int WORD_W = 16;
  localparam int DIV_LO_W = 8;
  localparam int DIV_HI_W = DIV_W - DIV_LO_W;

  // Word bit positions
  localparam int B_INT_EN = 0;
  localparam int B_STABLE = 1;
  localparam int B_CARD_EN = 2;
  localparam int B_PLL = 3;
  localparam int B_DIV_HI = 6;
  localparam int B_DIV_LO = 8;

  // Strobes from the control side to the generator
  typedef struct packed {
    logic run;
    logic [DIV_W-1:0] div;
  } dpCtl_t;
endpackage

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              clkStable,
  output dpCtl_t            dpCtl
);
  localparam int CNT_W = (STABLE_CYCLES < 1) ? 1 : $clog2(STABLE_CYCLES + 1);

  logic intEn;
  logic cardEn;
  logic pllEn;
  logic [DIV_W-1:0] divReg;

  // Field register. Write data on bits 1 and 5:4 is dropped.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn  <= 1'b0;
      cardEn <= 1'b0;
      pllEn  <= 1'b0;
      divReg <= '0;
    end else if (wrEn) begin
      intEn  <= wrData[B_INT_EN];
      cardEn <= wrData[B_CARD_EN];
      pllEn  <= wrData[B_PLL];
      divReg <= {wrData[B_DIV_HI +: DIV_HI_W], wrData[B_DIV_LO +: DIV_LO_W]};
    end
  end

  // Settle timer: chosen by the parameter
  generate
    if (STABLE_CYCLES == 0) begin : g_noSettle
      assign clkStable = intEn;
    end else begin : g_settle
      logic [CNT_W-1:0] stCnt;
      logic clearing;
      assign clearing = wrEn && !wrData[B_INT_EN];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stCnt <= '0;
        end else if (clearing || !intEn) begin
          stCnt <= '0;
        end else if (stCnt != CNT_W'(STABLE_CYCLES)) begin
          stCnt <= stCnt + 1'b1;
        end
      end
      assign clkStable = (stCnt == CNT_W'(STABLE_CYCLES));
    end
  endgenerate

  always_comb begin
    rdData = '0;
    rdData[B_INT_EN] = intEn;
    rdData[B_STABLE] = clkStable;
    rdData[B_CARD_EN] = cardEn;
    rdData[B_PLL] = pllEn;
    rdData[B_DIV_HI +: DIV_HI_W] = divReg[DIV_W-1 -: DIV_HI_W];
    rdData[B_DIV_LO +: DIV_LO_W] = divReg[DIV_LO_W-1:0];
  end

  assign dpCtl.run = intEn & clkStable & cardEn;
  assign dpCtl.div = divReg;

  assert_stable_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStable) |-> (intEn && $past(intEn)));

  assert_stable_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intEn) |-> !clkStable);
endmodule

// File: rtl/cardclk_dp.sv
module cardclk_dp
  import cardclk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t dpCtl,
  output logic   cardLevel,
  output logic   cardTick
);
  logic running;
  logic phaseHi;
  logic [DIV_W-1:0] actDiv;
  logic [DIV_W-1:0] cnt;
  logic divZero;
  logic lastHalf;
  logic periodEnd;

  assign divZero   = (actDiv == '0);
  assign lastHalf  = (cnt == actDiv - 1'b1);
  assign periodEnd = divZero || (!phaseHi && lastHalf);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phaseHi <= 1'b1;
      actDiv  <= '0;
      cnt     <= '0;
    end else if (!dpCtl.run) begin
      running <= 1'b0;
      phaseHi <= 1'b1;
      cnt     <= '0;
    end else if (!running || periodEnd) begin
      // Start, or period boundary: the only point where the divider reloads
      running <= 1'b1;
      actDiv  <= dpCtl.div;
      phaseHi <= 1'b1;
      cnt     <= '0;
    end else if (lastHalf) begin
      phaseHi <= 1'b0;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cardLevel = running && dpCtl.run && (divZero || phaseHi);
  assign cardTick  = running && dpCtl.run && (divZero || (phaseHi && cnt == '0));

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.run |=> !running);

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (running && !divZero) |-> (cnt < actDiv));

  assert_div_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$past(periodEnd)) |-> $stable(actDiv));

  assert_start_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(running) && dpCtl.run) |-> cardTick);
endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider
  import cardclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        clkStable,
  output logic        cardLevel,
  output logic        cardTick
);
  dpCtl_t dpCtl;

  cardclk_ctrl #(.STABLE_CYCLES(STABLE_CYCLES)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .wrData(wrData),
    .rdData(rdData),
    .clkStable(clkStable),
    .dpCtl(dpCtl)
  );

  cardclk_dp u_dp (
    .clk(clk),
    .rstN(rstN),
    .dpCtl(dpCtl),
    .cardLevel(cardLevel),
    .cardTick(cardTick)
  );
endmodule

// File: tb/cardclk_divider_bench.sv
module cardclk_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic clkStable, cardLevel, cardTick;

  cardclk_divider #(.STABLE_CYCLES(SETTLE)) u_cardclk_divider (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .clkStable(clkStable),
    .cardLevel(cardLevel), .cardTick(cardTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int period;
    int high;
    string tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit haveStart = 0;
  bit cardOn = 0;
  int startCyc = 0;
  int hiCnt = 0;

  function automatic logic [15:0] enc(input logic [9:0] div, input logic [3:0] low);
    return {div[7:0], div[9:8], 2'b00, low};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic pushPeriods(input int n, input int count, input string tag);
    for (int i = 0; i < count; i++) begin
      exp_t e;
      e.period = (n == 0) ? 1 : 2 * n;
      e.high = (n == 0) ? 1 : n;
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  // Caller stands just after a falling edge; returns just after the next one.
  task automatic wr(input logic [15:0] v);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    #1;
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic syncTick();
    while (q.size() != 0) @(negedge clk);
    do begin
      @(negedge clk);
      #1;
    end while (!cardTick);
  endtask

  // Monitor: measures each completed card clock period against the queue
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (cardTick) begin
        if (haveStart && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          vectors++;
          if ((cyc - startCyc) != e.period || hiCnt != e.high) begin
            miscompares++;
            $display("FAIL %s period/high actual=%0d/%0d expected=%0d/%0d",
                     e.tag, cyc - startCyc, hiCnt, e.period, e.high);
          end
        end
        haveStart = 1;
        startCyc = cyc;
        hiCnt = 0;
      end
      if (cardLevel) hiCnt++;
      if (!cardOn) haveStart = 0;
    end
    if (cyc > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    rstN = 1'b1;
    // R1: reset state
    check(rdData == 16'h0000, "R1 rdData", rdData, 16'h0000);
    check({clkStable, cardLevel, cardTick} == 3'b000, "R1 outputs",
          {13'b0, clkStable, cardLevel, cardTick}, 16'h0000);

    // R5: bits 1 and 5:4 ignored
    wr(16'h0032);
    check(rdData == 16'h0000, "R5 ignored bits", rdData, 16'h0000);
    check(clkStable == 1'b0, "R5 stable not writable", {15'b0, clkStable}, 16'h0000);

    // R2/R6: field placement, internal enable + PLL bit, card off
    wr(enc(10'h2A5, 4'h9));
    check(rdData == enc(10'h2A5, 4'h9), "R2 divider fields", rdData, enc(10'h2A5, 4'h9));
    // R3: settle delay counted from the write edge
    for (int k = 1; k <= SETTLE; k++) begin
      @(negedge clk);
      #1;
      if (k == SETTLE - 1)
        check(clkStable == 1'b0, "R3 not yet stable", {15'b0, clkStable}, 16'h0000);
      if (k == SETTLE)
        check(clkStable == 1'b1 && rdData[1], "R3 stable", {15'b0, clkStable}, 16'h0001);
    end
    // R7: no card clock without card enable
    check(cardLevel == 1'b0 && cardTick == 1'b0, "R7 gated off",
          {14'b0, cardLevel, cardTick}, 16'h0000);

    // R7/R8: start with divider 3
    cardOn = 1;
    wr(enc(10'd3, 4'hD));
    check(cardTick == 1'b0, "R7 no tick before start", {15'b0, cardTick}, 16'h0000);
    pushPeriods(3, 4, "R8 div3");
    @(negedge clk);
    #1;
    check(cardTick && cardLevel, "R7 first tick", {14'b0, cardLevel, cardTick}, 16'h0003);

    // R10: change 3 -> 1 mid-period
    syncTick();
    pushPeriods(3, 1, "R10 old div3");
    pushPeriods(1, 4, "R8 div1");
    wr(enc(10'd1, 4'hD));

    // R10: change 1 -> 5
    syncTick();
    pushPeriods(1, 1, "R10 old div1");
    pushPeriods(5, 3, "R8 div5");
    wr(enc(10'd5, 4'hD));

    // R9: change 5 -> 0 (pass-through)
    syncTick();
    pushPeriods(5, 1, "R10 old div5");
    pushPeriods(0, 6, "R9 div0");
    wr(enc(10'd0, 4'hD));
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    #1;

    // R6: clearing the PLL bit changes nothing on the card clock
    wr(enc(10'd0, 4'h5));
    check(rdData == 16'h0007, "R6 readback", rdData, 16'h0007);
    @(negedge clk);
    #1;
    check(cardTick && cardLevel, "R6 PLL no effect", {14'b0, cardLevel, cardTick}, 16'h0003);

    // R7: clearing card enable stops the clock at once
    cardOn = 0;
    wr(enc(10'd0, 4'h1));
    check(!cardLevel && !cardTick, "R7 stop", {14'b0, cardLevel, cardTick}, 16'h0000);
    begin
      bit anyHigh = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        #1;
        if (cardLevel || cardTick) anyHigh = 1;
      end
      check(!anyHigh, "R7 held low", {15'b0, anyHigh}, 16'h0000);
    end

    // R4: clearing internal enable drops stable in the same cycle
    wr(16'h0000);
    check(clkStable == 1'b0, "R4 stable cleared", {15'b0, clkStable}, 16'h0000);
    check(rdData == 16'h0000, "R4 readback", rdData, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule